// File: doc/BRIEF.md
# PWM Timing Register Double Buffer

This block sits between a software register write port and a PWM timer. Software writes a shadow copy of the output configuration byte, the mode byte and four 16-bit compare values (set and reset points for channels A and B) at any time. The PWM engine reads only the working copy. When the timer reports the end of a cycle, the whole shadow set moves into the working set in one clock edge, so a cycle never runs with some old and some new values. Stopping a cycle early is simply an early end-of-cycle pulse; the update happens on that pulse, and the next cycle starts on the new values.

Two controls decide whether a given cycle end performs the transfer. A manual hold bit blocks it. An automatic mode allows it only when the last register committed was the channel-B reset compare, and this mode overrides the hold bit. A change of the automatic mode bit takes effect only at the first cycle end after the write. A half-and-half mode bit in the working mode byte makes channel A show channel B's set and reset compare values, so channel A needs no programming.

Compare values are written as two bytes through a shared holding byte. Writing the high byte only loads the holding byte. Writing the low byte commits both bytes into the shadow register.

Top module: `pwm_dbuf_ctrl`

## Requirements
- R1: After synchronous reset, all working outputs are zero, the hold bit is clear and automatic mode is off.
- R2: The working outputs change only on the clock edge at which `cyc_end` is high, and all changed fields come from the same shadow set.
- R3: Address map: 0x0 control (bit0 hold, bit1 automatic mode), 0x1 output configuration, 0x2 mode; compare values SA at 0x4/0x5, RA at 0x6/0x7, SB at 0x8/0x9, RB at 0xA/0xB, with the even address being the high byte and the odd address the low byte. A high-byte write loads a single shared holding byte and changes no shadow register. A low-byte write commits {holding byte, low byte}.
- R4: While the hold bit is 1 and automatic mode is inactive, a cycle end transfers nothing. After the hold bit returns to 0, the next cycle end transfers the pending set.
- R5: While automatic mode is active, a cycle end transfers only if the most recent commit was to RB (a low-byte write at 0xB). A later commit to 0x1, 0x2, SA, RA or SB cancels this until RB is committed again. After a transfer, a new RB commit is needed.
- R6: A write to the automatic mode bit takes effect at the first cycle end after it. The transfer decision at that cycle end still follows the previous mode.
- R7: While automatic mode is active, the hold bit has no effect on the transfer.
- R8: When working mode bit0 is 1, `cmp_sa` shows working SB and `cmp_ra` shows working RB. The working SA and RA values are kept, and they show again when the bit returns to 0.
- R9: If a commit and a transferring cycle end fall in the same cycle, the transfer takes the shadow contents from before that write. The new value stays pending for the next qualifying cycle end.
- R10: Writes to addresses 0x3 and 0xC to 0xF have no effect. Cycle ends on consecutive clocks are each handled as a complete cycle end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| cyc_end | input | 1 | End-of-PWM-cycle pulse from the timer |
| out_cfg | output | 8 | Working output configuration byte |
| out_mode | output | 8 | Working mode byte (bit0 half-and-half) |
| cmp_sa | output | 16 | Channel A set compare (mirrored from SB in half mode) |
| cmp_ra | output | 16 | Channel A reset compare (mirrored from RB in half mode) |
| cmp_sb | output | 16 | Channel B set compare |
| cmp_rb | output | 16 | Channel B reset compare |

## Verification
A software commit and a cycle-end transfer can fall on the same clock. So can a control write that changes the hold or automatic bit and the cycle end whose decision that bit would affect. The bench provokes both by driving a low-byte write, or a control write, together with `cyc_end` on one edge. The outcome is judged against a behavioural model that applies the transfer using the state from before the edge and then records the write. Compares on every later clock show the value transferred at once, or pending until the next qualifying cycle end.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    localparam int BYTE_W  = 8;
    localparam int CMP_W   = 2 * BYTE_W;
    localparam int NUM_CMP = 4;
    localparam int ADDR_W  = 4;
    localparam int IDX_W   = $clog2(NUM_CMP);

    localparam int MODE_HALF_BIT = 0;
    localparam int CTRL_HOLD_BIT = 0;
    localparam int CTRL_AUTO_BIT = 1;

    typedef enum logic [IDX_W-1:0] {
        CMP_SA = 2'd0,
        CMP_RA = 2'd1,
        CMP_SB = 2'd2,
        CMP_RB = 2'd3
    } cmp_idx_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 4'h0,
        A_OUTCFG = 4'h1,
        A_MODE   = 4'h2,
        A_CMP_LO = 4'h4,
        A_CMP_HI = 4'hB
    } addr_e;

    typedef struct packed {
        logic [BYTE_W-1:0]               outcfg;
        logic [BYTE_W-1:0]               mode;
        logic [NUM_CMP-1:0][CMP_W-1:0]   cmp;
    } reg_set_t;

    function automatic logic is_cmp_addr(input logic [ADDR_W-1:0] a);
        return (a >= A_CMP_LO) && (a <= A_CMP_HI);
    endfunction

    // 4,6,8,A map to SA,RA,SB,RB
    function automatic cmp_idx_e cmp_index(input logic [ADDR_W-1:0] a);
        return cmp_idx_e'(a[2:1] ^ 2'b10);
    endfunction

    function automatic logic is_low_byte(input logic [ADDR_W-1:0] a);
        return a[0];
    endfunction

endpackage

// File: rtl/pwm_dbuf_wrport.sv
module pwm_dbuf_wrport
    import pwm_dbuf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                xfer,
    output reg_set_t            shadow_o,
    output logic                pending_o,
    output logic                last_rb_o,
    output logic                commit_o,
    output logic                ctrl_we_o,
    output logic                ctrl_hold_o,
    output logic                ctrl_auto_o
);

    logic               sel_cmp;
    logic               sel_lo;
    cmp_idx_e           sel_idx;
    logic               commit_cfg;
    logic               commit_mode;
    logic               commit_cmp;
    logic               commit_rb;
    logic [BYTE_W-1:0]  hold_byte;
    logic [BYTE_W-1:0]  shd_cfg;
    logic [BYTE_W-1:0]  shd_mode;
    logic               pending_q;
    logic               last_rb_q;

    always_comb begin
        sel_cmp     = is_cmp_addr(wr_addr);
        sel_lo      = is_low_byte(wr_addr);
        sel_idx     = cmp_index(wr_addr);
        commit_cfg  = wr_en && (wr_addr == A_OUTCFG);
        commit_mode = wr_en && (wr_addr == A_MODE);
        commit_cmp  = wr_en && sel_cmp && sel_lo;
        commit_rb   = commit_cmp && (sel_idx == CMP_RB);
        commit_o    = commit_cfg || commit_mode || commit_cmp;
        ctrl_we_o   = wr_en && (wr_addr == A_CTRL);
        ctrl_hold_o = wr_data[CTRL_HOLD_BIT];
        ctrl_auto_o = wr_data[CTRL_AUTO_BIT];
    end

    // holding byte and byte-wide shadow registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_byte <= '0;
            shd_cfg   <= '0;
            shd_mode  <= '0;
        end else begin
            if (wr_en && sel_cmp && !sel_lo)
                hold_byte <= wr_data;
            if (commit_cfg)
                shd_cfg <= wr_data;
            if (commit_mode)
                shd_mode <= wr_data;
        end
    end

    // compare shadows, one register per index
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_shd
        logic [CMP_W-1:0] val;
        always_ff @(posedge clk) begin
            if (rst)
                val <= '0;
            else if (commit_cmp && (sel_idx == cmp_idx_e'(i)))
                val <= {hold_byte, wr_data};
        end
        assign shadow_o.cmp[i] = val;
    end

    assign shadow_o.outcfg = shd_cfg;
    assign shadow_o.mode   = shd_mode;

    // a commit this cycle wins over the clear by a transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            last_rb_q <= 1'b0;
        end else if (commit_o) begin
            pending_q <= 1'b1;
            last_rb_q <= commit_rb;
        end else if (xfer) begin
            pending_q <= 1'b0;
            last_rb_q <= 1'b0;
        end
    end

    assign pending_o = pending_q;
    assign last_rb_o = last_rb_q;

endmodule

// File: rtl/pwm_dbuf_gate.sv
module pwm_dbuf_gate (
    input  logic clk,
    input  logic rst,
    input  logic cyc_end,
    input  logic ctrl_we,
    input  logic ctrl_hold,
    input  logic ctrl_auto,
    input  logic pending,
    input  logic last_rb,
    output logic xfer,
    output logic hold_o,
    output logic auto_o
);

    logic hold_q;
    logic auto_req_q;
    logic auto_act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b0;
            auto_req_q <= 1'b0;
        end else if (ctrl_we) begin
            hold_q     <= ctrl_hold;
            auto_req_q <= ctrl_auto;
        end
    end

    // requested mode becomes active only at a cycle end
    always_ff @(posedge clk) begin
        if (rst)
            auto_act_q <= 1'b0;
        else if (cyc_end)
            auto_act_q <= auto_req_q;
    end

    always_comb begin
        if (auto_act_q)
            xfer = cyc_end && pending && last_rb;
        else
            xfer = cyc_end && pending && !hold_q;
    end

    assign hold_o = hold_q;
    assign auto_o = auto_act_q;

endmodule

// File: rtl/pwm_dbuf_bank.sv
module pwm_dbuf_bank
    import pwm_dbuf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                xfer,
    input  reg_set_t            shadow,
    output logic [BYTE_W-1:0]   out_cfg,
    output logic [BYTE_W-1:0]   out_mode,
    output logic [CMP_W-1:0]    cmp_sa,
    output logic [CMP_W-1:0]    cmp_ra,
    output logic [CMP_W-1:0]    cmp_sb,
    output logic [CMP_W-1:0]    cmp_rb
);

    logic [BYTE_W-1:0] wk_cfg;
    logic [BYTE_W-1:0] wk_mode;
    logic [CMP_W-1:0]  wk_cmp [NUM_CMP];
    logic              half;

    always_ff @(posedge clk) begin
        if (rst) begin
            wk_cfg  <= '0;
            wk_mode <= '0;
        end else if (xfer) begin
            wk_cfg  <= shadow.outcfg;
            wk_mode <= shadow.mode;
        end
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_wk
        logic [CMP_W-1:0] val;
        always_ff @(posedge clk) begin
            if (rst)
                val <= '0;
            else if (xfer)
                val <= shadow.cmp[i];
        end
        assign wk_cmp[i] = val;
    end

    assign half     = wk_mode[MODE_HALF_BIT];
    assign out_cfg  = wk_cfg;
    assign out_mode = wk_mode;
    assign cmp_sb   = wk_cmp[CMP_SB];
    assign cmp_rb   = wk_cmp[CMP_RB];
    assign cmp_sa   = half ? wk_cmp[CMP_SB] : wk_cmp[CMP_SA];
    assign cmp_ra   = half ? wk_cmp[CMP_RB] : wk_cmp[CMP_RA];

endmodule

// File: rtl/pwm_dbuf_ctrl.sv
module pwm_dbuf_ctrl
    import pwm_dbuf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                cyc_end,
    output logic [BYTE_W-1:0]   out_cfg,
    output logic [BYTE_W-1:0]   out_mode,
    output logic [CMP_W-1:0]    cmp_sa,
    output logic [CMP_W-1:0]    cmp_ra,
    output logic [CMP_W-1:0]    cmp_sb,
    output logic [CMP_W-1:0]    cmp_rb
);

    reg_set_t shadow;
    logic     pending;
    logic     last_rb;
    logic     commit;
    logic     ctrl_we;
    logic     ctrl_hold;
    logic     ctrl_auto;
    logic     xfer;
    logic     hold_q;
    logic     auto_q;

    pwm_dbuf_wrport u_wr (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .xfer        (xfer),
        .shadow_o    (shadow),
        .pending_o   (pending),
        .last_rb_o   (last_rb),
        .commit_o    (commit),
        .ctrl_we_o   (ctrl_we),
        .ctrl_hold_o (ctrl_hold),
        .ctrl_auto_o (ctrl_auto)
    );

    pwm_dbuf_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .cyc_end   (cyc_end),
        .ctrl_we   (ctrl_we),
        .ctrl_hold (ctrl_hold),
        .ctrl_auto (ctrl_auto),
        .pending   (pending),
        .last_rb   (last_rb),
        .xfer      (xfer),
        .hold_o    (hold_q),
        .auto_o    (auto_q)
    );

    pwm_dbuf_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .xfer     (xfer),
        .shadow   (shadow),
        .out_cfg  (out_cfg),
        .out_mode (out_mode),
        .cmp_sa   (cmp_sa),
        .cmp_ra   (cmp_ra),
        .cmp_sb   (cmp_sb),
        .cmp_rb   (cmp_rb)
    );

endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk
    import pwm_dbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cyc_end,
    input logic              xfer,
    input logic              commit,
    input logic              pending,
    input logic              last_rb,
    input logic              hold_q,
    input logic              auto_q,
    input logic [BYTE_W-1:0] out_cfg,
    input logic [BYTE_W-1:0] out_mode,
    input logic [CMP_W-1:0]  cmp_sa,
    input logic [CMP_W-1:0]  cmp_ra,
    input logic [CMP_W-1:0]  cmp_sb,
    input logic [CMP_W-1:0]  cmp_rb
);

    logic [6*CMP_W-1:0] outs;
    assign outs = {out_cfg, out_mode, cmp_sa, cmp_ra, cmp_sb, cmp_rb};

    // R2
    stable_between_ends_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cyc_end) |-> $stable(outs));

    // R2
    xfer_at_end_only_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |-> cyc_end);

    // R4
    hold_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && hold_q && !auto_q) |=> $stable(outs));

    // R5
    auto_needs_rb_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && auto_q && !last_rb) |=> $stable(outs));

    // R5
    flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && !commit) |=> (!pending && !last_rb));

    // R9
    commit_sets_pending_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> pending);

endmodule

bind pwm_dbuf_ctrl pwm_dbuf_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc_end  (cyc_end),
    .xfer     (xfer),
    .commit   (commit),
    .pending  (pending),
    .last_rb  (last_rb),
    .hold_q   (hold_q),
    .auto_q   (auto_q),
    .out_cfg  (out_cfg),
    .out_mode (out_mode),
    .cmp_sa   (cmp_sa),
    .cmp_ra   (cmp_ra),
    .cmp_sb   (cmp_sb),
    .cmp_rb   (cmp_rb)
);

// File: tb/pwm_dbuf_ctrl_tb.sv
module pwm_dbuf_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cyc_end = 1'b0;
    logic [7:0]  out_cfg, out_mode;
    logic [15:0] cmp_sa, cmp_ra, cmp_sb, cmp_rb;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // reference model state
    logic [7:0]  m_hold;
    logic [7:0]  s_cfg, s_mode, w_cfg, w_mode;
    logic [15:0] s_cmp [4];
    logic [15:0] w_cmp [4];
    bit m_lock, m_areq, m_aact, m_pend, m_lrb;

    always #4 clk = ~clk;

    pwm_dbuf_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cyc_end(cyc_end), .out_cfg(out_cfg),
        .out_mode(out_mode), .cmp_sa(cmp_sa), .cmp_ra(cmp_ra),
        .cmp_sb(cmp_sb), .cmp_rb(cmp_rb)
    );

    task automatic cmp(input string tag, input string nm, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [15:0] e_sa, e_ra;
        e_sa = w_mode[0] ? w_cmp[2] : w_cmp[0];
        e_ra = w_mode[0] ? w_cmp[3] : w_cmp[1];
        cmp(tag, "out_cfg",  out_cfg,  w_cfg);
        cmp(tag, "out_mode", out_mode, w_mode);
        cmp(tag, "cmp_sa",   cmp_sa,   e_sa);
        cmp(tag, "cmp_ra",   cmp_ra,   e_ra);
        cmp(tag, "cmp_sb",   cmp_sb,   w_cmp[2]);
        cmp(tag, "cmp_rb",   cmp_rb,   w_cmp[3]);
    endtask

    task automatic model_reset();
        m_hold = 0; s_cfg = 0; s_mode = 0; w_cfg = 0; w_mode = 0;
        for (int i = 0; i < 4; i++) begin s_cmp[i] = 0; w_cmp[i] = 0; end
        m_lock = 0; m_areq = 0; m_aact = 0; m_pend = 0; m_lrb = 0;
    endtask

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(input bit we, input logic [3:0] a, input logic [7:0] d,
                        input bit ce, input string tag);
        bit xf, com;
        int idx;
        wr_en = we; wr_addr = a; wr_data = d; cyc_end = ce;
        @(posedge clk);
        xf = ce && m_pend && (m_aact ? m_lrb : !m_lock);
        if (xf) begin
            w_cfg = s_cfg; w_mode = s_mode;
            for (int i = 0; i < 4; i++) w_cmp[i] = s_cmp[i];
            m_pend = 0; m_lrb = 0;
        end
        if (ce) m_aact = m_areq;
        com = 0;
        if (we) begin
            if (a == 4'h0) begin m_lock = d[0]; m_areq = d[1]; end
            else if (a == 4'h1) begin s_cfg = d; com = 1; end
            else if (a == 4'h2) begin s_mode = d; com = 1; end
            else if (a >= 4'h4 && a <= 4'hB) begin
                idx = (a - 4) / 2;
                if (a[0] == 1'b0) m_hold = d;
                else begin
                    s_cmp[idx] = {m_hold, d};
                    com = 1;
                    m_pend = 1;
                    m_lrb = (idx == 3);
                end
            end
            if (com && a < 4'h4) begin m_pend = 1; m_lrb = 0; end
        end
        @(negedge clk);
        wr_en = 0; cyc_end = 0;
        compare_all(tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        step(1, a, d, 0, tag);
    endtask
    task automatic wr16(input logic [3:0] hi, input logic [15:0] v, input string tag);
        step(1, hi, v[15:8], 0, tag);
        step(1, hi + 4'h1, v[7:0], 0, tag);
    endtask
    task automatic endc(input string tag);
        step(0, 4'h0, 8'h00, 1, tag);
    endtask
    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 4'h0, 8'h00, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        compare_all("R1");
        cmp("R1", "cmp_sa_zero", cmp_sa, 0);

        // R3 / R2: byte protocol, outputs stay until cycle end
        wr16(4'h8, 16'h1234, "R3");
        wr(4'h1, 8'hA5, "R2");
        idle(3, "R2");
        cmp("R2", "cmp_sb_before_end", cmp_sb, 16'h0000);
        endc("R2");
        cmp("R3", "cmp_sb_after_end", cmp_sb, 16'h1234);
        cmp("R2", "out_cfg_after_end", out_cfg, 8'hA5);
        wr(4'h6, 8'h77, "R3");
        endc("R3");
        cmp("R3", "ra_high_only", cmp_ra, 16'h0000);
        wr(4'h7, 8'h01, "R3");
        endc("R3");
        cmp("R3", "ra_uses_held", cmp_ra, 16'h7701);

        // R10: unmapped addresses ignored
        wr(4'h3, 8'hFF, "R10");
        wr(4'hC, 8'hFF, "R10");
        wr(4'hF, 8'hFF, "R10");
        endc("R10");
        cmp("R10", "cfg_unchanged", out_cfg, 8'hA5);

        // R4: manual hold
        wr(4'h0, 8'h01, "R4");
        wr(4'h1, 8'h3C, "R4");
        endc("R4");
        cmp("R4", "held_cfg", out_cfg, 8'hA5);
        endc("R4");
        wr(4'h0, 8'h00, "R4");
        idle(2, "R4");
        endc("R4");
        cmp("R4", "released_cfg", out_cfg, 8'h3C);

        // R6: request automatic mode; first end still manual
        wr(4'h0, 8'h02, "R6");
        wr(4'h2, 8'h80, "R6");
        endc("R6");
        cmp("R6", "mode_via_manual", out_mode, 8'h80);
        // R5: automatic active, last commit not RB
        wr16(4'h4, 16'hBEEF, "R5");
        endc("R5");
        cmp("R5", "no_rb_no_xfer", cmp_sa, 16'h0000);
        wr16(4'hA, 16'h4321, "R5");
        endc("R5");
        cmp("R5", "rb_xfer", cmp_rb, 16'h4321);
        cmp("R5", "sa_with_rb", cmp_sa, 16'hBEEF);
        wr16(4'hA, 16'h5555, "R5");
        wr16(4'h8, 16'h6666, "R5");
        endc("R5");
        cmp("R5", "rb_cancelled", cmp_rb, 16'h4321);
        wr16(4'hA, 16'h5556, "R5");
        endc("R5");
        cmp("R5", "rb_again", cmp_rb, 16'h5556);
        endc("R5");

        // R7: hold ignored in automatic mode
        wr(4'h0, 8'h03, "R7");
        wr16(4'hA, 16'h7A7A, "R7");
        endc("R7");
        cmp("R7", "auto_over_hold", cmp_rb, 16'h7A7A);

        // R6: leave automatic mode; control write and end in same cycle
        step(1, 4'h0, 8'h00, 1, "R6");
        wr(4'h1, 8'h11, "R6");
        endc("R6");
        cmp("R6", "still_auto", out_cfg, 8'h3C);
        wr(4'h1, 8'h12, "R6");
        endc("R6");
        cmp("R6", "manual_again", out_cfg, 8'h12);

        // R9: commit and transferring cycle end on the same edge
        wr(4'h1, 8'h21, "R9");
        step(1, 4'h2, 8'h00, 1, "R9");
        cmp("R9", "cfg_from_old_shadow", out_cfg, 8'h21);
        cmp("R9", "mode_not_yet", out_mode, 8'h80);
        endc("R9");
        cmp("R9", "mode_next_end", out_mode, 8'h00);
        step(1, 4'h8, 8'h9A, 1, "R9");
        step(1, 4'h9, 8'hBC, 1, "R9");
        cmp("R9", "sb_pending", cmp_sb, 16'h6666);
        endc("R9");
        cmp("R9", "sb_landed", cmp_sb, 16'h9ABC);

        // R8: half-and-half mirror
        wr16(4'h4, 16'h0A0A, "R8");
        wr16(4'h6, 16'h0B0B, "R8");
        wr(4'h2, 8'h01, "R8");
        endc("R8");
        cmp("R8", "sa_mirrors_sb", cmp_sa, 16'h9ABC);
        cmp("R8", "ra_mirrors_rb", cmp_ra, 16'h7A7A);
        wr(4'h2, 8'h00, "R8");
        endc("R8");
        cmp("R8", "sa_restored", cmp_sa, 16'h0A0A);
        cmp("R8", "ra_restored", cmp_ra, 16'h0B0B);

        // R10: back-to-back cycle ends with writes between
        step(1, 4'h1, 8'h44, 1, "R10");
        step(1, 4'h1, 8'h45, 1, "R10");
        endc("R10");
        cmp("R10", "back_to_back", out_cfg, 8'h45);
        idle(2, "R10");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule